// File: doc/BRIEF.md
# Multiprocessor UART Receive Address Filter

This block follows a UART receiver that hands over 9-bit characters. Each character is an 8-bit byte, plus a marker that says whether the byte is a node address or data. A framing-error bit and a one-cycle valid strobe come with it. The filter decides which of these characters raise a receive interrupt. The decision depends on a filter enable bit, a 2-bit policy field and an 8-bit node address. With every interrupt it presents the byte and two flags. One flag marks an address byte. The other marks the first data byte of a frame that was addressed to this node.

For the two compare policies, a small state machine tracks frame membership. Its states are `FR_OUTSIDE` (the current frame is not for this node), `FR_OPEN` (a matching address was seen and no data byte has been accepted yet) and `FR_INSIDE` (the frame is matched and its first data byte has already been delivered).

The transitions are named as follows:
- `ADDR_HIT`: from any state to `FR_OPEN`, on an address byte equal to the node address.
- `ADDR_MISS`: from any state to `FR_OUTSIDE`, on an address byte that differs from the node address.
- `FIRST_DATA`: from `FR_OPEN` to `FR_INSIDE`, on a data byte without a framing error.
- `RESTART`: to `FR_OUTSIDE`, when the enable bit or the policy field changes to a compare policy.

Reset leaves the machine in `FR_OUTSIDE`. In every other case the state holds. Outputs are registered and appear one clock after the strobe.

Top module: `mp_rx_filter`

## Requirements
- R1: After reset, `irq`, `flag_addr` and `flag_newfrm` are 0 and the frame state is `FR_OUTSIDE`. So in policy 2'b10, a data byte sent before any address byte raises no interrupt.
- R2: With `mp_en`=0, every valid character raises `irq` one cycle later with `irq_data` equal to the byte, and both flags are 0.
- R3: In policy 2'b00 with `mp_en`=1, every valid character raises `irq`. `flag_addr` equals the marker bit `rx_is_addr` (1 = address), and `flag_newfrm` is 0.
- R4: In policy 2'b01 with `mp_en`=1, every address byte raises `irq` with `flag_addr`=1, whatever its value. A data byte never raises `irq`.
- R5: In policy 2'b10, an address byte equal to `node_addr` raises `irq` with `flag_addr`=1, even if it has a framing error. An address byte that differs raises nothing.
- R6: In policies 2'b10 and 2'b11, data bytes after a differing address byte raise no interrupt until the next address byte. Error-free data bytes after a matching address byte each raise `irq` with `flag_addr`=0.
- R7: In policies 2'b10 and 2'b11, the first error-free data byte after a matching address byte has `flag_newfrm`=1. Later data bytes of that frame have `flag_newfrm`=0.
- R8: In policy 2'b11, no address byte raises an interrupt, matching or not.
- R9: In policies 2'b10 and 2'b11, a data byte with a framing error raises no interrupt. The frame state and the pending first-data mark are left unchanged, so the next error-free data byte still carries `flag_newfrm`=1 if no data byte had been accepted yet.
- R10: A change of `mp_en` or `mp_mode` that lands in a compare policy returns the frame state to `FR_OUTSIDE`. Data bytes after such a change raise nothing until a matching address byte arrives.
- R11: `irq` is high for exactly the one cycle after an accepted strobe and is 0 in cycles without a preceding strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mp_en | input | 1 | Filter enable |
| mp_mode | input | 2 | Policy: 00 all, 01 address only, 10 matched frame, 11 matched data only |
| node_addr | input | 8 | Address this node answers to |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_data | input | 8 | Received byte |
| rx_is_addr | input | 1 | Marker bit, 1 = address byte |
| rx_frame_err | input | 1 | Framing error on this character |
| irq | output | 1 | Receive interrupt strobe |
| irq_data | output | 8 | Byte delivered with the interrupt |
| flag_addr | output | 1 | Delivered byte is an address byte |
| flag_newfrm | output | 1 | Delivered byte is the first data byte of a matched frame |

## Verification
The bench builds the filter with the default 8-bit byte width, so every one of the 256 address values can be swept. The sweep runs for each enable setting and each of the four policies, and uses three node addresses: all zeros, all ones and a mixed pattern. After each address byte come a data byte with a framing error and two clean data bytes. This covers matching and non-matching frames, the pending first-data mark across an errored byte, and the reset of frame state on policy changes.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
    typedef enum logic [1:0] {
        FR_OUTSIDE = 2'd0,
        FR_OPEN    = 2'd1,
        FR_INSIDE  = 2'd2
    } frame_st_t;

    typedef enum logic [1:0] {
        MD_ALL        = 2'b00,
        MD_ADDR_ONLY  = 2'b01,
        MD_MATCH      = 2'b10,
        MD_MATCH_DATA = 2'b11
    } mp_mode_t;

    typedef struct packed {
        logic fire;
        logic is_addr;
        logic is_new;
    } verdict_t;
endpackage

// File: rtl/mpf_cfg_watch.sv
module mpf_cfg_watch #(
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mp_en,
    input  logic [MODE_W-1:0] mp_mode,
    output logic              restart
);
    localparam int CFG_W = MODE_W + 1;

    logic [CFG_W-1:0] cfg_now;
    logic [CFG_W-1:0] cfg_q;

    assign cfg_now = {mp_en, mp_mode};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_now;
    end

    // a change that lands in a compare policy forces a fresh search
    assign restart = (cfg_now != cfg_q) && mp_en && mp_mode[MODE_W-1];
endmodule

// File: rtl/mpf_addr_cmp.sv
module mpf_addr_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] own_addr,
    output logic              hit
);
    logic [DATA_W-1:0] diff;

    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_bit
            assign diff[g] = rx_byte[g] ^ own_addr[g];
        end
    endgenerate

    assign hit = ~|diff;
endmodule

// File: rtl/mpf_frame_fsm.sv
module mpf_frame_fsm
    import mpf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  logic      cmp_mode,
    input  logic      rx_valid,
    input  logic      rx_is_addr,
    input  logic      rx_frame_err,
    input  logic      addr_hit,
    output frame_st_t cur_st
);
    frame_st_t st_q;
    frame_st_t nxt;

    // RESTART overrides the stored state in the cycle it occurs
    assign cur_st = restart ? FR_OUTSIDE : st_q;

    always_comb begin
        nxt = cur_st;
        if (cmp_mode && rx_valid) begin
            if (rx_is_addr) begin
                nxt = addr_hit ? FR_OPEN : FR_OUTSIDE;    // ADDR_HIT / ADDR_MISS
            end else if (!rx_frame_err) begin
                unique case (cur_st)
                    FR_OPEN:    nxt = FR_INSIDE;          // FIRST_DATA
                    FR_INSIDE:  nxt = FR_INSIDE;
                    FR_OUTSIDE: nxt = FR_OUTSIDE;
                    default:    nxt = FR_OUTSIDE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FR_OUTSIDE;
        else        st_q <= nxt;
    end
endmodule

// File: rtl/mpf_policy.sv
module mpf_policy
    import mpf_pkg::*;
(
    input  logic      mp_en,
    input  mp_mode_t  mode,
    input  logic      rx_valid,
    input  logic      rx_is_addr,
    input  logic      rx_frame_err,
    input  logic      addr_hit,
    input  frame_st_t cur_st,
    output verdict_t  vd
);
    logic data_ok;
    logic in_frame;

    assign data_ok  = !rx_is_addr && !rx_frame_err;
    assign in_frame = (cur_st == FR_OPEN) || (cur_st == FR_INSIDE);

    always_comb begin
        vd = '0;
        if (rx_valid) begin
            if (!mp_en) begin
                vd.fire = 1'b1;
            end else begin
                unique case (mode)
                    MD_ALL: begin
                        vd.fire    = 1'b1;
                        vd.is_addr = rx_is_addr;
                    end
                    MD_ADDR_ONLY: begin
                        vd.fire    = rx_is_addr;
                        vd.is_addr = rx_is_addr;
                    end
                    MD_MATCH: begin
                        if (rx_is_addr) begin
                            vd.fire    = addr_hit;
                            vd.is_addr = addr_hit;
                        end else begin
                            vd.fire   = data_ok && in_frame;
                            vd.is_new = data_ok && (cur_st == FR_OPEN);
                        end
                    end
                    MD_MATCH_DATA: begin
                        vd.fire   = data_ok && in_frame;
                        vd.is_new = data_ok && (cur_st == FR_OPEN);
                    end
                    default: vd = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/mpf_out_stage.sv
module mpf_out_stage
    import mpf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  verdict_t          vd,
    input  logic [DATA_W-1:0] rx_data,
    output logic              irq,
    output logic [DATA_W-1:0] irq_data,
    output logic              flag_addr,
    output logic              flag_newfrm
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq         <= 1'b0;
            irq_data    <= '0;
            flag_addr   <= 1'b0;
            flag_newfrm <= 1'b0;
        end else begin
            irq         <= vd.fire;
            flag_addr   <= vd.fire && vd.is_addr;
            flag_newfrm <= vd.fire && vd.is_new;
            if (vd.fire) irq_data <= rx_data;
        end
    end
endmodule

// File: rtl/mp_rx_filter.sv
module mp_rx_filter
    import mpf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mp_en,
    input  logic [1:0]        mp_mode,
    input  logic [DATA_W-1:0] node_addr,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_is_addr,
    input  logic              rx_frame_err,
    output logic              irq,
    output logic [DATA_W-1:0] irq_data,
    output logic              flag_addr,
    output logic              flag_newfrm
);
    localparam int MODE_W = 2;

    logic      restart;
    logic      addr_hit;
    logic      cmp_mode;
    frame_st_t cur_st;
    verdict_t  vd;
    mp_mode_t  mode_e;

    assign mode_e   = mp_mode_t'(mp_mode);
    assign cmp_mode = mp_en && mp_mode[MODE_W-1];

    mpf_cfg_watch #(.MODE_W(MODE_W)) u_watch (
        .clk(clk), .rst_n(rst_n), .mp_en(mp_en), .mp_mode(mp_mode),
        .restart(restart)
    );

    mpf_addr_cmp #(.DATA_W(DATA_W)) u_cmp (
        .rx_byte(rx_data), .own_addr(node_addr), .hit(addr_hit)
    );

    mpf_frame_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .restart(restart), .cmp_mode(cmp_mode),
        .rx_valid(rx_valid), .rx_is_addr(rx_is_addr),
        .rx_frame_err(rx_frame_err), .addr_hit(addr_hit), .cur_st(cur_st)
    );

    mpf_policy u_pol (
        .mp_en(mp_en), .mode(mode_e), .rx_valid(rx_valid),
        .rx_is_addr(rx_is_addr), .rx_frame_err(rx_frame_err),
        .addr_hit(addr_hit), .cur_st(cur_st), .vd(vd)
    );

    mpf_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .vd(vd), .rx_data(rx_data),
        .irq(irq), .irq_data(irq_data), .flag_addr(flag_addr),
        .flag_newfrm(flag_newfrm)
    );
endmodule

// File: rtl/mp_rx_filter_chk.sv
module mp_rx_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mp_en,
    input logic [1:0] mp_mode,
    input logic       rx_valid,
    input logic       rx_is_addr,
    input logic       rx_frame_err,
    input logic       irq,
    input logic       flag_addr,
    input logic       flag_newfrm
);
    assert_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !irq);

    assert_bypass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !mp_en) |=> (irq && !flag_addr && !flag_newfrm));

    assert_all_bytes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mp_en && mp_mode == 2'b00) |=> (irq && flag_addr == $past(rx_is_addr)));

    assert_addr_only_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mp_en && mp_mode == 2'b01 && !rx_is_addr) |=> !irq);

    assert_addr_only_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mp_en && mp_mode == 2'b01 && rx_is_addr) |=> (irq && flag_addr));

    assert_silent_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mp_en && mp_mode == 2'b11 && rx_is_addr) |=> !irq);

    assert_ferr_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && mp_en && mp_mode[1] && !rx_is_addr && rx_frame_err) |=> !irq);

    assert_newfrm_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_newfrm |-> (irq && !flag_addr));
endmodule

bind mp_rx_filter mp_rx_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mp_en(mp_en), .mp_mode(mp_mode),
    .rx_valid(rx_valid), .rx_is_addr(rx_is_addr), .rx_frame_err(rx_frame_err),
    .irq(irq), .flag_addr(flag_addr), .flag_newfrm(flag_newfrm)
);

// File: tb/sim_mp_rx_filter.sv
`timescale 1ns/1ps
module sim_mp_rx_filter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mp_en = 1'b0;
    logic [1:0] mp_mode = 2'b00;
    logic [7:0] node_addr = 8'h00;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_is_addr = 1'b0;
    logic       rx_frame_err = 1'b0;
    logic       irq;
    logic [7:0] irq_data;
    logic       flag_addr;
    logic       flag_newfrm;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // model: 0 outside, 1 open, 2 inside
    int       mstate = 0;
    logic [2:0] mcfg = 3'b000;

    always #4 clk = ~clk;

    mp_rx_filter u0 (
        .clk(clk), .rst_n(rst_n), .mp_en(mp_en), .mp_mode(mp_mode),
        .node_addr(node_addr), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_is_addr(rx_is_addr), .rx_frame_err(rx_frame_err),
        .irq(irq), .irq_data(irq_data), .flag_addr(flag_addr),
        .flag_newfrm(flag_newfrm)
    );

    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic e, input logic [1:0] m);
        if ({e, m} != mcfg && e && m[1]) mstate = 0;   // R10
        mcfg = {e, m};
        mp_en = e;
        mp_mode = m;
        @(negedge clk);
    endtask

    task automatic send(input logic ia, input logic [7:0] d, input logic fe);
        logic ex_irq, ex_a, ex_n;
        logic hit, ok, inf;
        string tag;
        hit = (d == node_addr);
        ok  = !ia && !fe;
        inf = (mstate != 0);
        ex_irq = 0; ex_a = 0; ex_n = 0;
        if (!mp_en) begin
            ex_irq = 1; tag = "R2";
        end else if (mp_mode == 2'b00) begin
            ex_irq = 1; ex_a = ia; tag = "R3";
        end else if (mp_mode == 2'b01) begin
            ex_irq = ia; ex_a = ia; tag = "R4";
        end else begin
            if (ia) begin
                ex_irq = (mp_mode == 2'b10) && hit;
                ex_a = ex_irq;
                tag = (mp_mode == 2'b10) ? "R5" : "R8";
                mstate = hit ? 1 : 0;
            end else if (fe) begin
                tag = "R9";
            end else begin
                ex_irq = inf;
                ex_n = (mstate == 1);
                tag = ex_n ? "R7" : "R6";
                if (mstate == 1) mstate = 2;
            end
        end
        rx_valid = 1; rx_is_addr = ia; rx_data = d; rx_frame_err = fe;
        @(negedge clk);
        rx_valid = 0;
        check(tag, {1'b0, irq, 8'h00}, {1'b0, ex_irq, 8'h00});
        if (ex_irq) check(tag, {flag_addr, flag_newfrm, irq_data}, {ex_a, ex_n, d});
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {irq, flag_addr, flag_newfrm, 7'd0}, 10'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {irq, flag_addr, flag_newfrm, 7'd0}, 10'd0);
        // R1: compare policy with no address yet -> data suppressed
        node_addr = 8'h42;
        mp_en = 1; mp_mode = 2'b10; mcfg = 3'b110; mstate = 0;
        send(1'b0, 8'h42, 1'b0);
        // R11: idle cycle after a delivered byte
        send(1'b1, 8'h42, 1'b0);
        @(negedge clk);
        check("R11", {1'b0, irq, 8'h00}, 10'd0);
        // R9: errored data keeps pending first-data mark
        send(1'b0, 8'h11, 1'b1);
        send(1'b0, 8'h12, 1'b0);
        // R10: policy change drops the match
        send(1'b1, 8'h42, 1'b0);
        set_cfg(1'b1, 2'b11);
        send(1'b0, 8'h13, 1'b0);
        check("R10", {1'b0, irq, 8'h00}, 10'd0);
        // sweep
        for (int ni = 0; ni < 3; ni++) begin
            node_addr = (ni == 0) ? 8'h00 : (ni == 1) ? 8'hFF : 8'hA5;
            for (int e = 0; e < 2; e++) begin
                for (int m = 0; m < 4; m++) begin
                    set_cfg(e[0], m[1:0]);
                    for (int a = 0; a < 256; a++) begin
                        send(1'b1, a[7:0], a[3]);
                        send(1'b0, a[7:0] ^ 8'h5A, 1'b1);
                        send(1'b0, a[7:0] + 8'd1, 1'b0);
                        send(1'b0, ~a[7:0], 1'b0);
                    end
                end
            end
        end
        @(negedge clk);
        check("R11", {1'b0, irq, 8'h00}, 10'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule